// File: doc/BRIEF.md
# Multicycle Sixteen-Register Teaching Processor

This block is a small processor core that executes programs from a single word-addressed memory. It has no accumulator. Instead it has sixteen 16-bit general registers. Every instruction is one 16-bit word made of four 4-bit fields. Bits 15:12 hold the operation, and the lower three fields name registers, an 8-bit address or small constants. Each instruction takes exactly three clocks: an address phase, a decode phase and an execute phase.

The memory port is single and synchronous. Read data appears one clock after its address. Programs start at word 0x00. There are no separate I/O instructions. A keyboard word sits at address 0xFE and is read with an ordinary load. Storing to the display address (0xFF by default) also pulses a one-clock output strobe. A HALT operation freezes the core and raises `halted` until the next reset.

Top module: `mini_cpu`

## Requirements
- R1: While reset is low, `pc` is 0, `halted` is 0, `mem_we` and `out_valid` are 0, and `mem_addr` shows 0x00, so the first fetch after reset reads word 0x00.
- R2: Each instruction takes three clocks. The word at `pc` is latched as the instruction and `pc` steps by one. After a HALT placed as the k-th executed instruction, `halted` is high 3k clocks after reset is released.
- R3: LOAD (opcode 0x1) writes M[bits 7:0] into register bits 11:8. The keyboard word at 0xFE is read this way.
- R4: STORE (opcode 0x2) writes register bits 3:0 to M[bits 11:4]. It gives exactly one write pulse.
- R5: ADD (opcode 0x3) computes Rd(11:8) = Rs(7:4) + Rt(3:0), modulo 2^16. For example, 0x00A1 + 0x00FE = 0x019F.
- R6: The following ops write Rd(11:8) from Rs(7:4) and Rt(3:0):
  - MOVE (0x5) copies Rs.
  - NOT (0x6) inverts Rs.
  - AND (0x7), OR (0x8) and XOR (0x9) combine Rs and Rt bitwise.
- R7: INC (0xA) and DEC (0xB) change register bits 11:8 by +1 or -1, wrapping modulo 2^16.
- R8: ROTATE (0xC) rotates register bits 11:8 in place by the count in bits 7:4. It rotates left when bit 0 is 0 and right when bit 0 is 1.
- R9: JUMPZ (0xD) loads `pc` with bits 7:0 when register bits 11:8 is zero. Otherwise execution continues at the next word.
- R10: Opcodes 0x4, 0xE and 0xF change no register and write no memory.
- R11: HALT (0x0) sets `halted`. After that, `mem_we` stays 0 and `mem_addr` does not change until reset.
- R12: A STORE to `OUT_PORT` raises `out_valid` for exactly one clock, together with the write. A STORE to any other address leaves `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | DW | Data for a memory write |
| mem_rdata | input | DW | Read data, valid one clock after its address |
| mem_we | output | 1 | Memory write enable |
| out_valid | output | 1 | One-clock strobe for a store to the display address |
| halted | output | 1 | High once HALT has executed |

## Verification
The bench builds the core with its defaults: 16-bit data and a display port at 0xFF. At this size an eight-value operand set covers carry, wraparound, sign-bit and alternating-bit patterns. The bench sweeps every pair of these values through ADD, AND, OR and XOR. It sweeps every value through all sixteen rotate counts in both directions. Every 4-bit field position is exercised by loads and stores to scattered addresses. Jump tests cover zero and non-zero conditions. Further runs cover the unused opcodes, the keyboard and display words, and the frozen state after HALT.

// File: rtl/mini_cpu.sv
module mini_cpu #(
  parameter int DW = 16,
  parameter logic [7:0] OUT_PORT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [7:0]    mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          out_valid,
  output logic          halted
);
  localparam int FW = 4;
  localparam int NREG = 1 << FW;

  localparam logic [FW-1:0] OP_HALT = 4'h0, OP_LOAD = 4'h1, OP_STORE = 4'h2,
    OP_ADD = 4'h3, OP_MOVE = 4'h5, OP_NOT = 4'h6, OP_AND = 4'h7, OP_OR = 4'h8,
    OP_XOR = 4'h9, OP_INC = 4'hA, OP_DEC = 4'hB, OP_ROT = 4'hC, OP_JMPZ = 4'hD;

  typedef enum logic [1:0] {PH_FETCH, PH_DECODE, PH_EXEC} phase_t;

  phase_t        phase;
  logic [7:0]    pc;
  logic [15:0]   ir;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] opd, ops, opt;
  logic [DW-1:0] result;
  logic          rf_we;

  wire [FW-1:0] op  = ir[15:12];
  wire [FW-1:0] rd  = ir[11:8];
  wire [FW-1:0] rs  = ir[7:4];
  wire [FW-1:0] rt  = ir[3:0];
  wire [FW-1:0] nop = mem_rdata[15:12];
  wire in_exec   = (phase == PH_EXEC) && !halted;
  wire jump_take = in_exec && (op == OP_JMPZ) && (opd == '0);

  always_comb begin
    mem_addr = pc;
    if (!halted && phase == PH_DECODE && nop == OP_LOAD)
      mem_addr = mem_rdata[7:0];
    else if (!halted && phase == PH_EXEC && op == OP_STORE)
      mem_addr = ir[11:4];
  end

  assign mem_we    = in_exec && (op == OP_STORE);
  assign mem_wdata = opt;
  assign out_valid = mem_we && (ir[11:4] == OUT_PORT);

  logic [DW-1:0] rot_l, rot_r;
  assign rot_l = (opd << rs) | (opd >> (DW - int'(rs)));
  assign rot_r = (opd >> rs) | (opd << (DW - int'(rs)));

  always_comb begin
    rf_we  = in_exec;
    result = '0;
    case (op)
      OP_LOAD: result = mem_rdata;
      OP_ADD:  result = ops + opt;
      OP_MOVE: result = ops;
      OP_NOT:  result = ~ops;
      OP_AND:  result = ops & opt;
      OP_OR:   result = ops | opt;
      OP_XOR:  result = ops ^ opt;
      OP_INC:  result = opd + 1'b1;
      OP_DEC:  result = opd - 1'b1;
      OP_ROT:  result = rt[0] ? rot_r : rot_l;
      default: rf_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_FETCH;
      pc     <= '0;
      ir     <= '0;
      halted <= 1'b0;
      opd    <= '0;
      ops    <= '0;
      opt    <= '0;
    end else if (!halted) begin
      case (phase)
        PH_FETCH: phase <= PH_DECODE;
        PH_DECODE: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          opd   <= rf[mem_rdata[11:8]];
          ops   <= rf[mem_rdata[7:4]];
          opt   <= rf[mem_rdata[3:0]];
          phase <= PH_EXEC;
        end
        default: begin
          phase <= PH_FETCH;
          if (op == OP_HALT) halted <= 1'b1;
          if (jump_take) pc <= ir[7:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[rd] <= result;
    end
  end

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we && $stable(mem_addr));

  p_out_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DECODE && !halted) |=> pc == $past(pc) + 8'd1);

  p_write_after_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(phase) == PH_DECODE);

  p_jump_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_take |=> pc == $past(ir[7:0]));

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (pc == 8'd0 && !halted && !mem_we));
endmodule

// File: tb/test_mini_cpu.sv
module test_mini_cpu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, out_valid, halted;

  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [256];
  int          we_cnt = 0, out_cnt = 0, cyc = 0;
  logic [15:0] out_val = '0;
  int          total = 0, failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mini_cpu i_mini_cpu (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .out_valid(out_valid), .halted(halted));

  always @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (mem_we) we_cnt <= we_cnt + 1;
    if (out_valid) begin
      out_cnt <= out_cnt + 1;
      out_val <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      failed = failed + 1;
      total = total + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] o, a, b, c);
    return {o, a, b, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    ld_addr = a; ld_data = d; ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run(input int exp_edges, output int edges);
    edges = 0;
    rst_n = 1'b1;
    while (!halted && edges < 300) begin
      @(posedge clk); edges++; #1;
    end
    @(negedge clk);
    chk(edges == exp_edges, "R2 cycles to halt", 16'(edges), 16'(exp_edges));
  endtask

  task automatic alu_run(input logic [15:0] a, b, instr, input logic [3:0] sreg,
                         input logic [15:0] exp, input string req);
    int e, w0, o0;
    poke(8'h80, a); poke(8'h81, b); poke(8'h82, 16'hDEAD);
    poke(8'h00, ins(4'h1, 4'h1, 4'h8, 4'h0));
    poke(8'h01, ins(4'h1, 4'h2, 4'h8, 4'h1));
    poke(8'h02, instr);
    poke(8'h03, ins(4'h2, 4'h8, 4'h2, sreg));
    poke(8'h04, 16'h0000);
    w0 = we_cnt; o0 = out_cnt;
    run(15, e);
    chk(mem[8'h82] == exp, req, mem[8'h82], exp);
    chk(we_cnt - w0 == 1 && out_cnt == o0, "R4/R12 single write no strobe",
        16'(we_cnt - w0), 16'd1);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  logic [15:0] vals [8] = '{16'h0000, 16'hFFFF, 16'h00A1, 16'h00FE,
                            16'h8000, 16'h7FFF, 16'h5A5A, 16'h1234};

  initial begin
    int e;
    logic [31:0] dbl;
    logic [15:0] ex;
    @(negedge clk); @(negedge clk);
    chk(mem_addr == 8'h00 && !halted && !mem_we && !out_valid, "R1 reset state",
        {7'd0, halted, mem_addr}, 16'h0000);

    alu_run(16'h00A1, 16'h00FE, ins(4'h3, 4'h3, 4'h1, 4'h2), 4'h3, 16'h019F, "R5 add example");

    foreach (vals[i]) foreach (vals[j]) begin
      alu_run(vals[i], vals[j], ins(4'h3, 4'h3, 4'h1, 4'h2), 4'h3, 16'(vals[i] + vals[j]), "R5 add");
      alu_run(vals[i], vals[j], ins(4'h7, 4'h3, 4'h1, 4'h2), 4'h3, vals[i] & vals[j], "R6 and");
      alu_run(vals[i], vals[j], ins(4'h8, 4'h3, 4'h1, 4'h2), 4'h3, vals[i] | vals[j], "R6 or");
      alu_run(vals[i], vals[j], ins(4'h9, 4'h3, 4'h1, 4'h2), 4'h3, vals[i] ^ vals[j], "R6 xor");
    end

    foreach (vals[i]) begin
      alu_run(vals[i], 16'h1111, ins(4'h5, 4'h3, 4'h1, 4'h0), 4'h3, vals[i], "R6 move");
      alu_run(vals[i], 16'h1111, ins(4'h6, 4'h3, 4'h1, 4'h0), 4'h3, ~vals[i], "R6 not");
      alu_run(vals[i], 16'h1111, ins(4'hA, 4'h1, 4'h0, 4'h0), 4'h1, 16'(vals[i] + 16'd1), "R7 inc");
      alu_run(vals[i], 16'h1111, ins(4'hB, 4'h1, 4'h0, 4'h0), 4'h1, 16'(vals[i] - 16'd1), "R7 dec");
      for (int n = 0; n < 16; n++) begin
        dbl = {vals[i], vals[i]};
        ex = 16'((dbl << n) >> 16);
        alu_run(vals[i], 16'h1111, ins(4'hC, 4'h1, 4'(n), 4'h0), 4'h1, ex, "R8 rotate left");
        ex = 16'(dbl >> n);
        alu_run(vals[i], 16'h1111, ins(4'hC, 4'h1, 4'(n), 4'h1), 4'h1, ex, "R8 rotate right");
      end
    end

    foreach (vals[i]) begin
      alu_run(vals[i], 16'h2222, ins(4'h4, 4'h1, 4'h2, 4'h2), 4'h1, vals[i], "R10 opcode 4 no-op");
      alu_run(vals[i], 16'h2222, ins(4'hE, 4'h1, 4'h2, 4'h2), 4'h1, vals[i], "R10 opcode E no-op");
      alu_run(vals[i], 16'h2222, ins(4'hF, 4'h1, 4'h2, 4'h2), 4'h1, vals[i], "R10 opcode F no-op");
    end

    // R3 R4: scattered field positions
    poke(8'hC7, 16'hBEEF); poke(8'h3D, 16'h0000);
    poke(8'h00, ins(4'h1, 4'h9, 4'hC, 4'h7));
    poke(8'h01, ins(4'h2, 4'h3, 4'hD, 4'h9));
    poke(8'h02, 16'h0000);
    run(9, e);
    chk(mem[8'h3D] == 16'hBEEF, "R3/R4 load C7 store 3D", mem[8'h3D], 16'hBEEF);
    rst_n = 1'b0; @(negedge clk);

    // R9 jump on zero
    foreach (vals[i]) begin
      int w0;
      poke(8'h80, vals[i]); poke(8'h81, 16'h0777); poke(8'h82, 16'hDEAD);
      poke(8'h00, ins(4'h1, 4'h1, 4'h8, 4'h0));
      poke(8'h01, ins(4'h1, 4'h3, 4'h8, 4'h1));
      poke(8'h02, ins(4'hD, 4'h1, 4'h0, 4'h5));
      poke(8'h03, ins(4'hA, 4'h3, 4'h0, 4'h0));
      poke(8'h04, 16'h0000);
      poke(8'h05, ins(4'h2, 4'h8, 4'h2, 4'h3));
      poke(8'h06, 16'h0000);
      w0 = we_cnt;
      run(15, e);
      ex = (vals[i] == 16'h0) ? 16'h0777 : 16'hDEAD;
      chk(mem[8'h82] == ex, "R9 jump if zero", mem[8'h82], ex);
      chk(we_cnt - w0 == ((vals[i] == 16'h0) ? 1 : 0), "R9 path writes",
          16'(we_cnt - w0), (vals[i] == 16'h0) ? 16'd1 : 16'd0);
      rst_n = 1'b0; @(negedge clk);
    end

    // R12 keyboard in, display out
    begin
      int o0;
      poke(8'hFE, 16'h4321);
      poke(8'h00, ins(4'h1, 4'h5, 4'hF, 4'hE));
      poke(8'h01, ins(4'hA, 4'h5, 4'h0, 4'h0));
      poke(8'h02, ins(4'h2, 4'hF, 4'hF, 4'h5));
      poke(8'h03, 16'h0000);
      o0 = out_cnt;
      run(12, e);
      chk(out_cnt - o0 == 1, "R12 one strobe cycle", 16'(out_cnt - o0), 16'd1);
      chk(out_val == 16'h4322, "R12 display value", out_val, 16'h4322);
      chk(mem[8'hFF] == 16'h4322, "R3/R12 keyboard via load", mem[8'hFF], 16'h4322);
    end

    // R11 frozen after halt
    begin
      logic [7:0] a0;
      int w0;
      a0 = mem_addr; w0 = we_cnt;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        chk(halted && mem_addr == a0, "R11 halted and frozen", {7'd0, halted, mem_addr}, {8'd1, a0});
      end
      chk(we_cnt == w0, "R11 no write after halt", 16'(we_cnt - w0), 16'd0);
      rst_n = 1'b0; @(negedge clk);
      chk(!halted && mem_addr == 8'h00, "R1 reset clears halt", {7'd0, halted, mem_addr}, 16'h0000);
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule